// File: doc/BRIEF.md
# PHY Control-Bus Handshake Master

This block turns single register commands into the full four-phase handshake sequence that a PHY's 16-bit control bus expects, so that software never has to toggle strobe bits by hand. A command (read or write, a 16-bit register address and 16-bit write data) is offered on a valid/ready port. The block places values on one shared 16-bit `ctl_din` bus and pulses one of four strobes per phase: capture-address, capture-data, read or write. After each strobe rises it waits for the acknowledge line to go high, drops the strobe, then waits for acknowledge to go low before it starts the next phase.

A read runs an address phase and then a read phase. The read value is taken from `ctl_dout` while acknowledge is high. A write runs an address phase, a capture-data phase with the write value on `ctl_din`, and then a write phase. The acknowledge input passes through a two-flop synchronizer. Each wait is timed against a programmable limit, and a wait that runs out of time ends the command with an error.

The command port applies back-pressure: `cmd_ready` is low for the whole time a command is in flight, and the command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. The response is a one-cycle `rsp_valid` pulse with no back-pressure. The consumer must take it in that cycle.

Top module: `phy_cbus_master`

## Requirements
- R1: `cmd_ready` is high exactly when no command is in flight. A `cmd_valid` that is held high while a command is in flight starts nothing.
- R2: `busy` rises in the cycle after acceptance and stays high until the cycle in which `rsp_valid` pulses, when it is low again.
- R3: Every command begins with an address phase. `ctl_din` carries the address before `stb_addr` rises. The strobe stays high until the synchronized acknowledge is high, and the block then waits for acknowledge low before it starts the next phase.
- R4: A read is an address phase followed by a read-strobe phase, with `ctl_din` still holding the address. `rsp_rdata` is the `ctl_dout` value present while acknowledge was high in that read phase, and `rsp_error` is 0.
- R5: A write is an address phase, then a capture-data phase with `ctl_din` equal to the write data, then a write-strobe phase, and nothing else.
- R6: At most one of the four strobes is high in any cycle. All of them are low while `busy` is low.
- R7: `ctl_din` does not change while any strobe is high.
- R8: `ctl_ack` reaches the sequencer through two flops. A wait counter starts at 0 when a strobe rises or falls and counts up every cycle. The phase completes if the synchronized acknowledge shows the awaited level while the count is at most `tmo_limit`, even when the count equals `tmo_limit`. If it does not, the block pulses `rsp_valid` with `rsp_error`=1 and returns to idle with all strobes low. With a responder that changes `ctl_ack` D cycles after the strobe changes, a phase succeeds if and only if D+1 <= `tmo_limit`.
- R9: `rsp_valid` is high for exactly one cycle per accepted command. `rsp_error` is high only together with `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken (idle) |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 16 | Register address |
| cmd_wdata | input | 16 | Write value |
| tmo_limit | input | 16 | Maximum wait count per handshake edge |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read value |
| rsp_error | output | 1 | Acknowledge timeout on this command |
| busy | output | 1 | Command in flight |
| stb_addr | output | 1 | Capture-address strobe |
| stb_data | output | 1 | Capture-data strobe |
| stb_read | output | 1 | Read strobe |
| stb_write | output | 1 | Write strobe |
| ctl_din | output | 16 | Shared address/data bus to the PHY |
| ctl_ack | input | 1 | PHY acknowledge (asynchronous) |
| ctl_dout | input | 16 | PHY read data |

## Verification
Two events can fall in the same cycle: the wait counter reaching `tmo_limit` and the synchronized acknowledge reaching the awaited level. The bench sets `tmo_limit` to 6 and runs a bench responder with a delay of 5, so that acknowledge arrives exactly at the limit. That command must complete cleanly with correct read data. A delay of 6 must end in an error after only the address strobe. The bench checks both outcomes against the R8 rule. Its per-clock model checks `busy`, `cmd_ready` and strobe exclusivity throughout, and it checks that the block recovers and runs a normal read after the timeout.

// File: rtl/cbus_pkg.sv
package cbus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_RAISE = 2'd2,
    ST_DROP  = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_ADDR = 2'd0,
    PH_DATA = 2'd1,
    PH_XFER = 2'd2
  } phase_e;
endpackage

// File: rtl/cbus_ack_sync.sv
module cbus_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/cbus_phase_timer.sv
module cbus_phase_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wait_en,
  input  logic          restart,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (!wait_en || restart) cnt_q <= '0;
    else if (cnt_q != limit)     cnt_q <= cnt_q + 1'b1;
  end

  assign expired = wait_en && (cnt_q == limit);
endmodule

// File: rtl/cbus_sequencer.sv
module cbus_sequencer
  import cbus_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_write,
  input  logic [DW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  input  logic          ack_s,
  input  logic [DW-1:0] ctl_dout,
  input  logic          expired,
  output logic          cmd_ready,
  output logic          busy,
  output logic          waiting,
  output logic          advance,
  output logic          stb_addr,
  output logic          stb_data,
  output logic          stb_read,
  output logic          stb_write,
  output logic [DW-1:0] ctl_din,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_error
);
  seq_state_e    state_q;
  phase_e        phase_q;
  logic          is_wr_q;
  logic [DW-1:0] din_q, wdata_q, rdata_q;
  logic          met, high;

  assign met     = (state_q == ST_RAISE && ack_s) || (state_q == ST_DROP && !ack_s);
  assign waiting = (state_q == ST_RAISE) || (state_q == ST_DROP);
  assign advance = waiting && met;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      phase_q   <= PH_ADDR;
      is_wr_q   <= 1'b0;
      din_q     <= '0;
      wdata_q   <= '0;
      rdata_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_error <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_error <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (cmd_valid) begin
          state_q <= ST_SETUP;
          phase_q <= PH_ADDR;
          is_wr_q <= cmd_write;
          din_q   <= cmd_addr;
          wdata_q <= cmd_wdata;
          rdata_q <= '0;
        end
        ST_SETUP: state_q <= ST_RAISE;
        ST_RAISE: begin
          if (met) begin
            state_q <= ST_DROP;
            if (phase_q == PH_XFER && !is_wr_q) rdata_q <= ctl_dout;
          end else if (expired) begin
            state_q   <= ST_IDLE;
            phase_q   <= PH_ADDR;
            rsp_valid <= 1'b1;
            rsp_error <= 1'b1;
          end
        end
        ST_DROP: begin
          if (met) begin
            unique case (phase_q)
              PH_ADDR: begin
                state_q <= ST_SETUP;
                phase_q <= is_wr_q ? PH_DATA : PH_XFER;
                if (is_wr_q) din_q <= wdata_q;
              end
              PH_DATA: begin
                state_q <= ST_SETUP;
                phase_q <= PH_XFER;
              end
              default: begin
                state_q   <= ST_IDLE;
                phase_q   <= PH_ADDR;
                rsp_valid <= 1'b1;
              end
            endcase
          end else if (expired) begin
            state_q   <= ST_IDLE;
            phase_q   <= PH_ADDR;
            rsp_valid <= 1'b1;
            rsp_error <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign high      = (state_q == ST_RAISE);
  assign stb_addr  = high && (phase_q == PH_ADDR);
  assign stb_data  = high && (phase_q == PH_DATA);
  assign stb_read  = high && (phase_q == PH_XFER) && !is_wr_q;
  assign stb_write = high && (phase_q == PH_XFER) && is_wr_q;
  assign ctl_din   = din_q;
  assign rsp_rdata = rdata_q;
  assign cmd_ready = (state_q == ST_IDLE);
  assign busy      = (state_q != ST_IDLE);
endmodule

// File: rtl/phy_cbus_master.sv
module phy_cbus_master #(
  parameter int DW = 16,
  parameter int TW = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_write,
  input  logic [DW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  input  logic [TW-1:0] tmo_limit,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_error,
  output logic          busy,
  output logic          stb_addr,
  output logic          stb_data,
  output logic          stb_read,
  output logic          stb_write,
  output logic [DW-1:0] ctl_din,
  input  logic          ctl_ack,
  input  logic [DW-1:0] ctl_dout
);
  logic ack_s, waiting, advance, expired;

  cbus_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(ctl_ack), .sync_o(ack_s)
  );

  cbus_phase_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .wait_en(waiting), .restart(advance),
    .limit(tmo_limit), .expired(expired)
  );

  cbus_sequencer #(.DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .ack_s(ack_s), .ctl_dout(ctl_dout), .expired(expired),
    .cmd_ready(cmd_ready), .busy(busy), .waiting(waiting), .advance(advance),
    .stb_addr(stb_addr), .stb_data(stb_data), .stb_read(stb_read), .stb_write(stb_write),
    .ctl_din(ctl_din), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_error(rsp_error)
  );
endmodule

// File: rtl/phy_cbus_master_chk.sv
module phy_cbus_master_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_ready,
  input logic          busy,
  input logic          rsp_valid,
  input logic          rsp_error,
  input logic          stb_addr,
  input logic          stb_data,
  input logic          stb_read,
  input logic          stb_write,
  input logic [DW-1:0] ctl_din
);
  logic any_stb;
  assign any_stb = stb_addr | stb_data | stb_read | stb_write;

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb_addr, stb_data, stb_read, stb_write}));
  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !any_stb);
  // R1
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready == !busy);
  // R7
  din_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_stb && $past(any_stb)) |-> $stable(ctl_din));
  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R9
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_error |-> rsp_valid);
  // R2
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rsp_valid);
endmodule

bind phy_cbus_master phy_cbus_master_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .busy(busy),
  .rsp_valid(rsp_valid), .rsp_error(rsp_error),
  .stb_addr(stb_addr), .stb_data(stb_data), .stb_read(stb_read), .stb_write(stb_write),
  .ctl_din(ctl_din)
);

// File: tb/phy_cbus_master_tb.sv
module phy_cbus_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [15:0] cmd_addr = '0, cmd_wdata = '0, tmo_limit = 16'd40;
  logic        cmd_ready, rsp_valid, rsp_error, busy;
  logic [15:0] rsp_rdata, ctl_din;
  logic        stb_addr, stb_data, stb_read, stb_write;
  logic        ctl_ack = 1'b0;
  logic [15:0] ctl_dout = 16'hFFFF;

  always #5 clk = ~clk;

  phy_cbus_master u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .tmo_limit(tmo_limit), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_error(rsp_error), .busy(busy), .stb_addr(stb_addr), .stb_data(stb_data),
    .stb_read(stb_read), .stb_write(stb_write), .ctl_din(ctl_din),
    .ctl_ack(ctl_ack), .ctl_dout(ctl_dout)
  );

  int checks = 0, fails = 0;
  int got_q[$];
  bit model_busy = 0, acc_seen = 0, mon_on = 0, finished = 0;
  bit prev_any = 0;
  int resp_delay = 1, resp_cnt = 0, done_seen = 0;
  logic [15:0] last_rdata;
  logic        last_err;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) acc_seen <= cmd_valid && cmd_ready;

  // Per-clock reference model and PHY responder
  always @(negedge clk) begin
    if (mon_on) begin
      if (acc_seen) model_busy = 1;
      if (rsp_valid) begin
        model_busy = 0;
        done_seen++;
        last_rdata = rsp_rdata;
        last_err = rsp_error;
      end
      chk(busy == model_busy, "R2", "busy", busy, model_busy);
      chk(cmd_ready == !model_busy, "R1", "cmd_ready", cmd_ready, !model_busy);
      chk($countones({stb_addr, stb_data, stb_read, stb_write}) <= 1, "R6", "strobe count",
          $countones({stb_addr, stb_data, stb_read, stb_write}), 1);
      if (!model_busy)
        chk(!(stb_addr | stb_data | stb_read | stb_write), "R6", "idle strobes",
            {stb_addr, stb_data, stb_read, stb_write}, 0);
    end
    begin
      bit any;
      any = stb_addr | stb_data | stb_read | stb_write;
      if (any && !prev_any)
        got_q.push_back((stb_addr ? 1 : stb_data ? 2 : stb_read ? 3 : 4) * 65536 + int'(ctl_din));
      prev_any = any;
      if (any && !ctl_ack) begin
        resp_cnt++;
        if (resp_cnt >= resp_delay) begin
          ctl_ack = 1'b1; resp_cnt = 0;
          ctl_dout = ctl_din ^ 16'h5A3C;
        end
      end else if (!any && ctl_ack) begin
        resp_cnt++;
        if (resp_cnt >= resp_delay) begin
          ctl_ack = 1'b0; resp_cnt = 0;
          ctl_dout = 16'hFFFF;
        end
      end else resp_cnt = 0;
    end
  end

  task automatic run_cmd(bit wr, logic [15:0] a, logic [15:0] d, int hold_extra);
    int start;
    got_q.delete();
    start = done_seen;
    @(negedge clk);
    cmd_valid = 1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    // keep offering a different command while busy (R1)
    cmd_addr = a ^ 16'h0F0F; cmd_wdata = d ^ 16'h00FF;
    for (int i = 0; i < hold_extra; i++) @(negedge clk);
    cmd_valid = 0;
    for (int i = 0; i < 500 && done_seen == start; i++) @(negedge clk);
    chk(done_seen == start + 1, "R9", "one done pulse", done_seen - start, 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_seq(string req, int exp[$]);
    chk(got_q.size() == exp.size(), req, "strobe count", got_q.size(), exp.size());
    for (int i = 0; i < exp.size() && i < got_q.size(); i++)
      chk(got_q[i] == exp[i], req, "strobe/din", got_q[i], exp[i]);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0, "R2", "reset busy", busy, 0);
    chk(cmd_ready == 1, "R1", "reset ready", cmd_ready, 1);
    chk({stb_addr, stb_data, stb_read, stb_write} == 0, "R6", "reset strobes",
        {stb_addr, stb_data, stb_read, stb_write}, 0);
    chk(rsp_valid == 0, "R9", "reset done", rsp_valid, 0);
    rst_n = 1;
    mon_on = 1;
    repeat (2) @(negedge clk);

    // R5 write sequence, with command held during busy (R1)
    run_cmd(1, 16'h1234, 16'hBEEF, 3);
    expect_seq("R5", '{1*65536 + 'h1234, 2*65536 + 'hBEEF, 4*65536 + 'hBEEF});
    chk(last_err == 0, "R5", "write error", last_err, 0);

    // R4 read sequence and data
    run_cmd(0, 16'h00A7, 16'h0000, 2);
    expect_seq("R4", '{1*65536 + 'h00A7, 3*65536 + 'h00A7});
    chk(last_rdata == (16'h00A7 ^ 16'h5A3C), "R4", "read data", last_rdata, 16'h00A7 ^ 16'h5A3C);
    chk(last_err == 0, "R4", "read error", last_err, 0);

    // R3 slower acknowledge
    resp_delay = 4;
    run_cmd(0, 16'hFFFF, 16'h0, 0);
    expect_seq("R3", '{1*65536 + 'hFFFF, 3*65536 + 'hFFFF});
    chk(last_rdata == (16'hFFFF ^ 16'h5A3C), "R3", "read data slow", last_rdata, 16'hFFFF ^ 16'h5A3C);

    // R8 acknowledge exactly at the limit
    tmo_limit = 16'd6; resp_delay = 5;
    run_cmd(0, 16'h0300, 16'h0, 0);
    chk(last_err == 0, "R8", "ack at limit error", last_err, 0);
    chk(last_rdata == (16'h0300 ^ 16'h5A3C), "R8", "ack at limit data", last_rdata, 16'h0300 ^ 16'h5A3C);
    run_cmd(1, 16'h0301, 16'h7777, 0);
    expect_seq("R8", '{1*65536 + 'h0301, 2*65536 + 'h7777, 4*65536 + 'h7777});

    // R8 acknowledge one cycle too late
    resp_delay = 6;
    run_cmd(0, 16'h0400, 16'h0, 0);
    chk(last_err == 1, "R8", "timeout error", last_err, 1);
    expect_seq("R8", '{1*65536 + 'h0400});
    repeat (20) @(negedge clk);
    chk(ctl_ack == 0, "R8", "responder idle", ctl_ack, 0);

    // recovery after timeout
    tmo_limit = 16'd40; resp_delay = 1;
    run_cmd(0, 16'h5555, 16'h0, 0);
    expect_seq("R4", '{1*65536 + 'h5555, 3*65536 + 'h5555});
    chk(last_err == 0, "R8", "recovery error", last_err, 0);
    chk(last_rdata == (16'h5555 ^ 16'h5A3C), "R4", "recovery data", last_rdata, 16'h5555 ^ 16'h5A3C);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule